// File: doc/BRIEF.md
# Delayed-Branch Next-PC Generator

This block holds the fetch address of a 32-bit RISC front end whose control transfers have one architectural delay slot. In each cycle in which the advance strobe is high it accepts the decoded control-transfer information for the instruction at the current fetch address. The inputs are the transfer class, the 26-bit absolute target field, the 16-bit branch offset, the value of the source register, the destination register index and a branch-taken flag. From these it computes the next fetch address. When the instruction is a linking jump, it also raises a link-register write request in that same cycle.

A redirect never changes the fetch that immediately follows the transfer. The next instruction in sequence, the delay slot, is always fetched. The computed target is held in a pending register and loaded into the program counter on the following advance. Region bits for absolute jumps, branch bases and link values are all taken from the delay-slot address. The upstream decoder, register file and branch comparator drive the inputs. A register-file write port consumes the link request.

Top module: `dbr_nextpc`

## Requirements
- R1: With `rst_n` low at a rising clock edge, `fetch_pc_o` becomes the parameter `RST_VEC` and any pending redirect is discarded. The next accepted instruction then advances by 4.
- R2: While `adv_i` is low, `fetch_pc_o` keeps its value and `link_we_o` stays low, whatever the other inputs are.
- R3: An accepted instruction that is not in a delay slot always moves `fetch_pc_o` to its own address + 4, including a taken jump or branch. The transfer class encoding on `xfer_kind_i` is 0 none, 1 jump, 2 jump-and-link, 3 jump-register, 4 jump-and-link-register and 5 conditional branch. Codes 6 and 7 act as none.
- R4: For classes 1 and 2, the address fetched after the delay slot is formed from two parts. Bits 31:28 are bits 31:28 of the delay-slot address (jump address + 4). Bits 27:0 are `tgt26_i` shifted left by two.
- R5: For classes 3 and 4, the address fetched after the delay slot is `rs_val_i` as presented with the jump.
- R6: For class 5 with `taken_i` high, the address fetched after the delay slot is the delay-slot address plus the sign-extended `off16_i` shifted left by two. With `taken_i` low, fetch continues sequentially.
- R7: An accepted class-2 instruction raises `link_we_o` in its own accept cycle, with `link_idx_o` = 31 and `link_val_o` = jump address + 8.
- R8: An accepted class-4 instruction raises `link_we_o` in its accept cycle, with `link_idx_o` = `rd_idx_i` and `link_val_o` = jump address + 8. When `rd_idx_i` is 0, the write is suppressed.
- R9: A control-transfer instruction accepted in a delay slot causes no redirect and no link write. The held target is fetched next, and fetch then continues sequentially from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| adv_i | input | 1 | Advance strobe: the instruction at `fetch_pc_o` is accepted this cycle |
| xfer_kind_i | input | 3 | Transfer class of the accepted instruction |
| tgt26_i | input | 26 | Absolute jump target field |
| off16_i | input | 16 | Signed branch offset in words |
| rs_val_i | input | 32 | Source register value for register jumps |
| rd_idx_i | input | 5 | Destination register index for the register jump-and-link |
| taken_i | input | 1 | Branch condition result |
| fetch_pc_o | output | 32 | Current fetch address |
| link_we_o | output | 1 | Link-register write enable |
| link_idx_o | output | 5 | Link-register write index |
| link_val_o | output | 32 | Link-register write value |

## Verification
The fetch sequence is driven with each transfer class in turn, so that every target rule is separated from the plain increment by 4. The first jump sits just below a 256 MB boundary. Its delay slot lies in the next region, so using the jump's own region bits would give a visibly different target. Branches are tried taken backward, taken forward and not taken, which separates the sign extension and delay-slot base from sequential flow. Transfers placed in delay slots, held cycles carrying a linking jump, a register link to index 0, and a reset in the middle of a delay slot distinguish ignored stimulus from honoured stimulus.

// File: rtl/dbr_pkg.sv
// Package dbr_pkg
// Shared transfer-class encoding for the delayed-branch next-PC block.
// Assumes a 3-bit class field; unused codes behave as "no transfer".
package dbr_pkg;

    typedef enum logic [2:0] {
        XF_NONE = 3'd0,
        XF_J    = 3'd1,
        XF_JAL  = 3'd2,
        XF_JR   = 3'd3,
        XF_JALR = 3'd4,
        XF_BR   = 3'd5
    } xfer_e;

endpackage

// File: rtl/dbr_target_calc.sv
// Module dbr_target_calc
// Combinational redirect decision and target address for one instruction.
// Assumes pc_i is the address of the instruction being accepted; all
// relative and region computations use the delay-slot address pc_i + 4.
module dbr_target_calc
    import dbr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TGT_W  = 26,
    parameter int OFF_W  = 16
) (
    input  logic [2:0]        kind_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [TGT_W-1:0]  tgt_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [ADDR_W-1:0] rs_i,
    input  logic              taken_i,
    output logic              redir_o,
    output logic [ADDR_W-1:0] target_o
);

    localparam int REGION_W = ADDR_W - TGT_W - 2;
    localparam int SEXT_W   = ADDR_W - OFF_W - 2;

    logic [ADDR_W-1:0] slot_pc;
    logic [ADDR_W-1:0] abs_tgt;
    logic [ADDR_W-1:0] rel_tgt;
    xfer_e             kind;

    assign kind    = xfer_e'(kind_i);
    assign slot_pc = pc_i + ADDR_W'(4);

    // Absolute target: region bits of the delay-slot address over the field.
    generate
        if (REGION_W > 0) begin : g_region
            assign abs_tgt = {slot_pc[ADDR_W-1 -: REGION_W], tgt_i, 2'b00};
        end else begin : g_noregion
            assign abs_tgt = ADDR_W'({tgt_i, 2'b00});
        end
    endgenerate

    // Relative target: delay-slot address plus word offset.
    assign rel_tgt = slot_pc + {{SEXT_W{off_i[OFF_W-1]}}, off_i, 2'b00};

    // Select redirect and target by transfer class.
    always_comb begin
        redir_o  = 1'b0;
        target_o = abs_tgt;
        case (kind)
            XF_J, XF_JAL: begin
                redir_o  = 1'b1;
                target_o = abs_tgt;
            end
            XF_JR, XF_JALR: begin
                redir_o  = 1'b1;
                target_o = rs_i;
            end
            XF_BR: begin
                redir_o  = taken_i;
                target_o = rel_tgt;
            end
            default: begin
                redir_o  = 1'b0;
                target_o = abs_tgt;
            end
        endcase
    end

endmodule

// File: rtl/dbr_link_gen.sv
// Module dbr_link_gen
// Link-register write request for linking jumps, valid in the accept cycle.
// Assumes accept_i is already gated by the advance strobe and slot state.
module dbr_link_gen
    import dbr_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int RIDX_W   = 5,
    parameter int LINK_REG = 31
) (
    input  logic              accept_i,
    input  logic [2:0]        kind_i,
    input  logic [RIDX_W-1:0] rd_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic              we_o,
    output logic [RIDX_W-1:0] idx_o,
    output logic [ADDR_W-1:0] val_o
);

    localparam logic [RIDX_W-1:0] LINK_IDX = RIDX_W'(LINK_REG);

    xfer_e kind;
    assign kind = xfer_e'(kind_i);

    // Return address skips the delay slot.
    assign val_o = pc_i + ADDR_W'(8);

    // Destination choice and zero-index suppression.
    always_comb begin
        we_o  = 1'b0;
        idx_o = '0;
        if (accept_i) begin
            if (kind == XF_JAL) begin
                idx_o = LINK_IDX;
                we_o  = (LINK_IDX != '0);
            end else if (kind == XF_JALR) begin
                idx_o = rd_i;
                we_o  = (rd_i != '0);
            end
        end
    end

endmodule

// File: rtl/dbr_pc_seq.sv
// Module dbr_pc_seq
// Program counter with a one-entry pending-target register.
// Assumes redir_i/target_i describe the instruction at pc_o and are only
// honoured when no redirect is already pending (that instruction is then
// not a delay slot).
module dbr_pc_seq #(
    parameter int                ADDR_W  = 32,
    parameter logic [ADDR_W-1:0] RST_VEC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              redir_i,
    input  logic [ADDR_W-1:0] target_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic              pend_o,
    output logic [ADDR_W-1:0] pend_tgt_o
);

    // PC update: load the held target after the slot, else step by 4.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_o       <= RST_VEC;
            pend_o     <= 1'b0;
            pend_tgt_o <= '0;
        end else if (adv_i) begin
            if (pend_o) begin
                pc_o   <= pend_tgt_o;
                pend_o <= 1'b0;
            end else begin
                pc_o   <= pc_o + ADDR_W'(4);
                pend_o <= redir_i;
                if (redir_i) begin
                    pend_tgt_o <= target_i;
                end
            end
        end
    end

endmodule

// File: rtl/dbr_nextpc.sv
// Module dbr_nextpc
// Top of the delayed-branch next-PC generator: target calculation, link
// request generation and the PC/pending sequencer.
// Assumes the decoded inputs describe the instruction at fetch_pc_o.
module dbr_nextpc #(
    parameter int                ADDR_W   = 32,
    parameter int                TGT_W    = 26,
    parameter int                OFF_W    = 16,
    parameter int                RIDX_W   = 5,
    parameter int                LINK_REG = 31,
    parameter logic [ADDR_W-1:0] RST_VEC  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic [2:0]        xfer_kind_i,
    input  logic [TGT_W-1:0]  tgt26_i,
    input  logic [OFF_W-1:0]  off16_i,
    input  logic [ADDR_W-1:0] rs_val_i,
    input  logic [RIDX_W-1:0] rd_idx_i,
    input  logic              taken_i,
    output logic [ADDR_W-1:0] fetch_pc_o,
    output logic              link_we_o,
    output logic [RIDX_W-1:0] link_idx_o,
    output logic [ADDR_W-1:0] link_val_o
);

    logic              redir;
    logic [ADDR_W-1:0] target;
    logic              pend_q;
    logic [ADDR_W-1:0] pend_tgt_q;
    logic              accept_free;

    // An instruction counts as a transfer only outside a delay slot.
    assign accept_free = adv_i & ~pend_q;

    dbr_target_calc #(
        .ADDR_W (ADDR_W),
        .TGT_W  (TGT_W),
        .OFF_W  (OFF_W)
    ) calc_i (
        .kind_i   (xfer_kind_i),
        .pc_i     (fetch_pc_o),
        .tgt_i    (tgt26_i),
        .off_i    (off16_i),
        .rs_i     (rs_val_i),
        .taken_i  (taken_i),
        .redir_o  (redir),
        .target_o (target)
    );

    dbr_link_gen #(
        .ADDR_W   (ADDR_W),
        .RIDX_W   (RIDX_W),
        .LINK_REG (LINK_REG)
    ) link_i (
        .accept_i (accept_free),
        .kind_i   (xfer_kind_i),
        .rd_i     (rd_idx_i),
        .pc_i     (fetch_pc_o),
        .we_o     (link_we_o),
        .idx_o    (link_idx_o),
        .val_o    (link_val_o)
    );

    dbr_pc_seq #(
        .ADDR_W  (ADDR_W),
        .RST_VEC (RST_VEC)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (adv_i),
        .redir_i    (redir),
        .target_i   (target),
        .pc_o       (fetch_pc_o),
        .pend_o     (pend_q),
        .pend_tgt_o (pend_tgt_q)
    );

endmodule

// File: rtl/dbr_nextpc_chk.sv
// Module dbr_nextpc_chk
// Assertion checker for dbr_nextpc, attached by bind below.
// Assumes synchronous active-low reset; all properties disabled in reset.
module dbr_nextpc_chk #(
    parameter int ADDR_W = 32,
    parameter int RIDX_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adv_i,
    input logic [ADDR_W-1:0] fetch_pc_o,
    input logic              pend_q,
    input logic [ADDR_W-1:0] pend_tgt_q,
    input logic              link_we_o,
    input logic [RIDX_W-1:0] link_idx_o
);

    AST_HOLD_PC: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(fetch_pc_o)); // R2

    AST_HOLD_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |-> !link_we_o); // R2

    AST_SLOT_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !pend_q) |=> (fetch_pc_o == $past(fetch_pc_o) + ADDR_W'(4))); // R3

    AST_SLOT_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && pend_q) |=> (fetch_pc_o == $past(pend_tgt_q)) && !pend_q); // R9

    AST_SLOT_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !link_we_o); // R9

    AST_LINK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (link_idx_o != '0)); // R8

endmodule

bind dbr_nextpc dbr_nextpc_chk #(
    .ADDR_W (ADDR_W),
    .RIDX_W (RIDX_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (adv_i),
    .fetch_pc_o (fetch_pc_o),
    .pend_q     (pend_q),
    .pend_tgt_q (pend_tgt_q),
    .link_we_o  (link_we_o),
    .link_idx_o (link_idx_o)
);

// File: tb/dbr_nextpc_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task predicts the fetch address and pushes
// it into a queue; the monitor pops and compares one cycle later.
module dbr_nextpc_tb_top;

    localparam logic [31:0] RV = 32'h0FFF_FFF8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv_i = 1'b0;
    logic [2:0]  xfer_kind_i = 3'd0;
    logic [25:0] tgt26_i = '0;
    logic [15:0] off16_i = '0;
    logic [31:0] rs_val_i = '0;
    logic [4:0]  rd_idx_i = '0;
    logic        taken_i = 1'b0;
    logic [31:0] fetch_pc_o;
    logic        link_we_o;
    logic [4:0]  link_idx_o;
    logic [31:0] link_val_o;

    int checks = 0;
    int fails  = 0;

    logic [31:0] q_pc[$];
    string       q_tag[$];

    // Reference model state
    logic [31:0] m_pc;
    logic        m_pend;
    logic [31:0] m_tgt;

    always #2.5 clk = ~clk;

    dbr_nextpc #(.RST_VEC(RV)) dut_i (
        .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .xfer_kind_i(xfer_kind_i),
        .tgt26_i(tgt26_i), .off16_i(off16_i), .rs_val_i(rs_val_i),
        .rd_idx_i(rd_idx_i), .taken_i(taken_i), .fetch_pc_o(fetch_pc_o),
        .link_we_o(link_we_o), .link_idx_o(link_idx_o), .link_val_o(link_val_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare fetch address against the predicted value.
    always @(negedge clk) begin
        if (q_pc.size() > 0) begin
            check(q_tag.pop_front(), fetch_pc_o, q_pc.pop_front());
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        adv_i = 1'b0;
        #1;
        q_pc.push_back(RV);
        q_tag.push_back("R1 reset vector");
        m_pc = RV; m_pend = 1'b0; m_tgt = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Driver: apply one instruction, check link outputs, predict next PC.
    task automatic issue(input string tag, input logic adv, input logic [2:0] kind,
                         input logic [25:0] tgt, input logic [15:0] off,
                         input logic [31:0] rs, input logic [4:0] rd, input logic tk);
        logic [31:0] ds;
        logic        e_we;
        logic [4:0]  e_idx;
        logic [31:0] nxt;
        @(negedge clk);
        adv_i = adv; xfer_kind_i = kind; tgt26_i = tgt; off16_i = off;
        rs_val_i = rs; rd_idx_i = rd; taken_i = tk;
        #1;
        ds = m_pc + 32'd4;
        e_we = 1'b0; e_idx = '0;
        if (adv && !m_pend) begin
            if (kind == 3'd2) begin e_we = 1'b1; e_idx = 5'd31; end
            if (kind == 3'd4 && rd != 5'd0) begin e_we = 1'b1; e_idx = rd; end
        end
        check({tag, " link_we"}, {31'd0, link_we_o}, {31'd0, e_we});
        if (e_we) begin
            check({tag, " link_idx"}, {27'd0, link_idx_o}, {27'd0, e_idx});
            check({tag, " link_val"}, link_val_o, m_pc + 32'd8);
        end
        nxt = m_pc;
        if (adv) begin
            if (m_pend) begin
                nxt = m_tgt;
                m_pend = 1'b0;
            end else begin
                nxt = ds;
                case (kind)
                    3'd1, 3'd2: begin m_pend = 1'b1; m_tgt = {ds[31:28], tgt, 2'b00}; end
                    3'd3, 3'd4: begin m_pend = 1'b1; m_tgt = rs; end
                    3'd5: if (tk) begin
                        m_pend = 1'b1;
                        m_tgt = ds + {{14{off[15]}}, off, 2'b00};
                    end
                    default: ;
                endcase
            end
        end
        m_pc = nxt;
        q_pc.push_back(nxt);
        q_tag.push_back(tag);
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Stimulus
    initial begin
        do_reset();
        issue("R3 plain step", 1, 3'd0, 0, 0, 0, 0, 0);
        // J just below a 256 MB boundary: region bits come from the slot.
        issue("R3 J slot fetched", 1, 3'd1, 26'h40, 0, 0, 0, 0);
        issue("R4 J region from slot", 1, 3'd0, 0, 0, 0, 0, 0);
        issue("R2 hold with JAL", 0, 3'd2, 26'h200, 0, 0, 0, 0);
        issue("R2 hold again", 0, 3'd4, 0, 0, 32'h1234_0000, 5'd3, 0);
        issue("R7 JAL link", 1, 3'd2, 26'h200, 0, 0, 0, 0);
        issue("R9 JR in slot ignored", 1, 3'd3, 0, 0, 32'hDEAD_0000, 0, 0);
        issue("R4 after JAL step", 1, 3'd0, 0, 0, 0, 0, 0);
        issue("R5 JR", 1, 3'd3, 0, 0, 32'h2000_0010, 0, 0);
        issue("R5 JR target", 1, 3'd0, 0, 0, 0, 0, 0);
        issue("R8 JALR rd7", 1, 3'd4, 0, 0, 32'h3000_0000, 5'd7, 0);
        issue("R5 JALR target", 1, 3'd0, 0, 0, 0, 0, 0);
        issue("R8 JALR rd0 suppressed", 1, 3'd4, 0, 0, 32'h3000_0040, 5'd0, 0);
        issue("R5 JALR rd0 target", 1, 3'd0, 0, 0, 0, 0, 0);
        issue("R6 branch back", 1, 3'd5, 0, 16'hFFFC, 0, 0, 1);
        issue("R6 branch back target", 1, 3'd0, 0, 0, 0, 0, 0);
        issue("R6 branch not taken", 1, 3'd5, 0, 16'h0010, 0, 0, 0);
        issue("R6 not taken step", 1, 3'd0, 0, 0, 0, 0, 0);
        issue("R6 branch fwd", 1, 3'd5, 0, 16'h0002, 0, 0, 1);
        issue("R6 branch fwd target", 1, 3'd0, 0, 0, 0, 0, 0);
        issue("R6 branch fwd2", 1, 3'd5, 0, 16'h0001, 0, 0, 1);
        issue("R9 JAL in slot no link", 1, 3'd2, 26'h3FF, 0, 0, 0, 0);
        issue("R9 continue sequential", 1, 3'd1, 26'h10, 0, 0, 0, 0);
        // Reset inside a delay slot drops the pending target.
        do_reset();
        issue("R1 no pending after reset", 1, 3'd0, 0, 0, 0, 0, 0);
        issue("R1 sequential after reset", 1, 3'd0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        adv_i = 1'b0;
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule